// File: doc/BRIEF.md
# LCD Panel Power Sequencer

The block steps an LCD panel through timed power-up and power-down. Four panel outputs, namely panel power, data/control enable, data enable and backlight, rise in that order and fall in the reverse order. One shared down-counter times the gap between steps. Three programmable delay inputs set the gaps, and each delay serves the same pair of neighbouring outputs in both directions. A single enable request, synchronous to the sequencer clock, drives the whole sequence.

The data/control enable and the data enable also pass through two-flop synchronizers into the pixel clock domain. There they gate the outgoing pixel data and control bits. The synchronized data/control enable also drives a gate on the pixel clock. The gate opens and closes only while the pixel clock is low.

Top module: `lcd_pwr_seq`

## Requirements
- R1: While reset is low, the four panel outputs, `pix_data_o` and `pix_ctl_o` are all zero, and `pix_clk_o` stays low.
- R2: `en_i` goes high in the idle state. At the next clock edge panel power rises. Data/control enable rises `dly_pwr_dce_i`+1 edges later. Data enable rises `dly_dce_de_i`+1 edges after that. Backlight rises `dly_de_bl_i`+1 edges after that.
- R3: While fully powered, the backlight stays high as long as `en_i` is high. It falls on the first edge at which `en_i` is sampled low.
- R4: After the backlight falls, data enable falls `dly_de_bl_i`+1 edges later. Data/control enable falls `dly_dce_de_i`+1 edges after that. Panel power falls `dly_pwr_dce_i`+1 edges after that, and the block returns to idle.
- R5: `en_i` may return high after the backlight has fallen but before data enable falls. The backlight then rises again on the next edge, and the other outputs do not change.
- R6: Once data enable has fallen during power-down, `en_i` going high has no effect until the last power-down delay expires. Data/control enable still falls on schedule.
- R7: `en_i` may be high when the last power-down delay expires. Panel power then stays high, and a fresh power-up starts: data/control enable rises `dly_pwr_dce_i`+1 edges later.
- R8: `en_i` may drop during a power-up delay. The delay still runs to its end. At that point the most recently raised output falls instead of the next one rising, and power-down continues from there with the normal delays.
- R9: A delay value of zero makes the next step happen on the very next clock edge.
- R10: At most one of the four panel outputs changes on any clock edge.
- R11: In the pixel clock domain, `pix_data_o` equals `pix_data_i` while the synchronized data enable is high, and is zero otherwise. `pix_ctl_o` does the same with the synchronized data/control enable. Each change takes effect within four pixel clock cycles.
- R12: `pix_clk_o` follows `pix_clk_i` while the synchronized data/control enable is high, and is held low otherwise. It rises only at a rising edge of `pix_clk_i` and falls only while `pix_clk_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| en_i | input | 1 | Panel on request, synchronous to clk_i |
| dly_pwr_dce_i | input | 26 | Gap between panel power and data/control enable |
| dly_dce_de_i | input | 26 | Gap between data/control enable and data enable |
| dly_de_bl_i | input | 26 | Gap between data enable and backlight |
| pwr_en_o | output | 1 | Panel power enable |
| dce_en_o | output | 1 | Data/control enable |
| de_en_o | output | 1 | Data enable |
| bl_en_o | output | 1 | Backlight enable |
| pix_clk_i | input | 1 | Pixel clock |
| pix_data_i | input | 24 | Pixel data from the display pipeline |
| pix_ctl_i | input | 3 | Sync/control bits from the display pipeline |
| pix_clk_o | output | 1 | Gated pixel clock |
| pix_data_o | output | 24 | Gated pixel data |
| pix_ctl_o | output | 3 | Gated control bits |

## Verification
A full power-up followed by a full power-down with three different non-zero gaps shows that each delay is applied to the right pair of outputs in both directions, sampled one edge before and on the expected edge. Separate runs toggle `en_i` at chosen points: while the backlight-off delay runs, inside the middle power-down stage, at the final power-down step, and inside two different power-up stages. These runs tell apart the cases that turn back, the cases that ignore the request, and the cases that finish the step and then reverse. An all-zero delay run separates "next edge" from "no delay at all". Pixel-side probes at both clock phases, together with a watch on the edges of the gated clock, tell a clean gate from one that lets a runt pulse through.

// File: rtl/lcd_pwr_pkg.sv
package lcd_pwr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UP_PWR,   // power on, timing gap to data/control
    ST_UP_DCE,   // data/control on, timing gap to data
    ST_UP_DE,    // data on, timing gap to backlight
    ST_ON,       // fully up; backlight gap timed here on the way down
    ST_DN_DCE,   // data off, timing gap to data/control off
    ST_DN_LAST   // data/control off, timing gap to power off
  } seq_st_e;
endpackage

// File: rtl/lcd_dly_cnt.sv
module lcd_dly_cnt #(
  parameter int CNT_W = 26
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/lcd_seq_fsm.sv
module lcd_seq_fsm
  import lcd_pwr_pkg::*;
#(
  parameter int CNT_W = 26
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             done_i,
  input  logic [CNT_W-1:0] dly_pd_i,
  input  logic [CNT_W-1:0] dly_cd_i,
  input  logic [CNT_W-1:0] dly_db_i,
  output logic             load_o,
  output logic [CNT_W-1:0] dly_o,
  output logic             pwr_o,
  output logic             dce_o,
  output logic             de_o,
  output logic             bl_o
);
  seq_st_e st_q, st_n;
  logic pwr_q, dce_q, de_q, bl_q;
  logic pwr_n, dce_n, de_n, bl_n;

  always_comb begin
    st_n   = st_q;
    pwr_n  = pwr_q;
    dce_n  = dce_q;
    de_n   = de_q;
    bl_n   = bl_q;
    load_o = 1'b0;
    dly_o  = '0;
    unique case (st_q)
      ST_IDLE: if (en_i) begin
        pwr_n = 1'b1; load_o = 1'b1; dly_o = dly_pd_i; st_n = ST_UP_PWR;
      end
      ST_UP_PWR: if (done_i) begin
        if (en_i) begin
          dce_n = 1'b1; load_o = 1'b1; dly_o = dly_cd_i; st_n = ST_UP_DCE;
        end else begin
          pwr_n = 1'b0; st_n = ST_IDLE;
        end
      end
      ST_UP_DCE: if (done_i) begin
        if (en_i) begin
          de_n = 1'b1; load_o = 1'b1; dly_o = dly_db_i; st_n = ST_UP_DE;
        end else begin
          dce_n = 1'b0; load_o = 1'b1; dly_o = dly_pd_i; st_n = ST_DN_LAST;
        end
      end
      ST_UP_DE: if (done_i) begin
        if (en_i) begin
          bl_n = 1'b1; st_n = ST_ON;
        end else begin
          de_n = 1'b0; load_o = 1'b1; dly_o = dly_cd_i; st_n = ST_DN_DCE;
        end
      end
      ST_ON: begin
        if (en_i) begin
          bl_n = 1'b1;
        end else if (bl_q) begin
          bl_n = 1'b0; load_o = 1'b1; dly_o = dly_db_i;
        end else if (done_i) begin
          de_n = 1'b0; load_o = 1'b1; dly_o = dly_cd_i; st_n = ST_DN_DCE;
        end
      end
      ST_DN_DCE: if (done_i) begin
        dce_n = 1'b0; load_o = 1'b1; dly_o = dly_pd_i; st_n = ST_DN_LAST;
      end
      ST_DN_LAST: if (done_i) begin
        if (en_i) begin
          load_o = 1'b1; dly_o = dly_pd_i; st_n = ST_UP_PWR;  // turn back, power held
        end else begin
          pwr_n = 1'b0; st_n = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      pwr_q <= 1'b0;
      dce_q <= 1'b0;
      de_q  <= 1'b0;
      bl_q  <= 1'b0;
    end else begin
      st_q  <= st_n;
      pwr_q <= pwr_n;
      dce_q <= dce_n;
      de_q  <= de_n;
      bl_q  <= bl_n;
    end
  end

  assign pwr_o = pwr_q;
  assign dce_o = dce_q;
  assign de_o  = de_q;
  assign bl_o  = bl_q;
endmodule

// File: rtl/lcd_sync_bits.sv
module lcd_sync_bits #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/lcd_clk_gate.sv
module lcd_clk_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic clk_o
);
  logic en_q;

  // enable moves only while clk_i is low, so the AND cannot chop a pulse
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_i;
  end

  assign clk_o = clk_i & en_q;
endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq #(
  parameter int CNT_W       = 26,
  parameter int DATA_W      = 24,
  parameter int CTL_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [CNT_W-1:0]  dly_pwr_dce_i,
  input  logic [CNT_W-1:0]  dly_dce_de_i,
  input  logic [CNT_W-1:0]  dly_de_bl_i,
  output logic              pwr_en_o,
  output logic              dce_en_o,
  output logic              de_en_o,
  output logic              bl_en_o,
  input  logic              pix_clk_i,
  input  logic [DATA_W-1:0] pix_data_i,
  input  logic [CTL_W-1:0]  pix_ctl_i,
  output logic              pix_clk_o,
  output logic [DATA_W-1:0] pix_data_o,
  output logic [CTL_W-1:0]  pix_ctl_o
);
  localparam int NSYNC = 2;

  logic             cnt_load, cnt_done;
  logic [CNT_W-1:0] cnt_val;
  logic [NSYNC-1:0] pix_en_s;

  lcd_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .done_i   (cnt_done),
    .dly_pd_i (dly_pwr_dce_i),
    .dly_cd_i (dly_dce_de_i),
    .dly_db_i (dly_de_bl_i),
    .load_o   (cnt_load),
    .dly_o    (cnt_val),
    .pwr_o    (pwr_en_o),
    .dce_o    (dce_en_o),
    .de_o     (de_en_o),
    .bl_o     (bl_en_o)
  );

  lcd_dly_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cnt_load),
    .val_i  (cnt_val),
    .done_o (cnt_done)
  );

  lcd_sync_bits #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (pix_clk_i),
    .rst_ni (rst_ni),
    .d_i    ({de_en_o, dce_en_o}),
    .q_o    (pix_en_s)
  );

  lcd_clk_gate u_cg (
    .clk_i  (pix_clk_i),
    .rst_ni (rst_ni),
    .en_i   (pix_en_s[0]),
    .clk_o  (pix_clk_o)
  );

  assign pix_data_o = pix_data_i & {DATA_W{pix_en_s[1]}};
  assign pix_ctl_o  = pix_ctl_i  & {CTL_W{pix_en_s[0]}};
endmodule

// File: rtl/lcd_pwr_seq_chk.sv
module lcd_pwr_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic pwr_i,
  input logic dce_i,
  input logic de_i,
  input logic bl_i
);
  p_order_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bl_i |-> de_i) and (de_i |-> dce_i) and (dce_i |-> pwr_i));

  p_one_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({pwr_i, dce_i, de_i, bl_i} ^ $past({pwr_i, dce_i, de_i, bl_i})) <= 1);

  p_bl_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bl_i && !en_i) |=> !bl_i);

  p_dce_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dce_i) |-> $past(en_i));

  p_de_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(de_i) |-> $past(en_i));

  p_pwr_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_i) |-> !$past(en_i));
endmodule

bind lcd_pwr_seq lcd_pwr_seq_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .pwr_i  (pwr_en_o),
  .dce_i  (dce_en_o),
  .de_i   (de_en_o),
  .bl_i   (bl_en_o)
);

// File: tb/lcd_pwr_seq_tb.sv
module lcd_pwr_seq_tb_top;
  localparam int CW = 26;
  localparam int DW = 24;
  localparam int KW = 3;
  localparam logic [DW-1:0] PAT_D = 24'hA5C3F0;
  localparam logic [KW-1:0] PAT_C = 3'b101;

  logic clk_i = 1'b0, pix_clk_i = 1'b0, rst_ni = 1'b0, en_i = 1'b0;
  logic pix_win = 1'b0;
  logic [CW-1:0] d_pd, d_cd, d_db;
  logic pwr, dce, de, bl, pix_clk_o;
  logic [DW-1:0] pix_data_o;
  logic [KW-1:0] pix_ctl_o;

  int n_chk = 0, n_err = 0, n_glitch = 0, n_multi = 0;
  int P, C, B;
  logic [3:0] prev_o;

  lcd_pwr_seq dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .dly_pwr_dce_i(d_pd), .dly_dce_de_i(d_cd), .dly_de_bl_i(d_db),
    .pwr_en_o(pwr), .dce_en_o(dce), .de_en_o(de), .bl_en_o(bl),
    .pix_clk_i(pix_clk_i), .pix_data_i(PAT_D), .pix_ctl_i(PAT_C),
    .pix_clk_o(pix_clk_o), .pix_data_o(pix_data_o), .pix_ctl_o(pix_ctl_o)
  );

  always #4 clk_i = ~clk_i;

  initial forever begin
    pix_clk_i = 1'b1; pix_win = 1'b1;
    #1 pix_win = 1'b0;
    #5 pix_clk_i = 1'b0;
    #6;
  end

  // R12 edge watch on the gated clock
  always @(posedge pix_clk_o) if (pix_win !== 1'b1) n_glitch++;
  always @(negedge pix_clk_o) if (pix_clk_i !== 1'b0) n_glitch++;

  // R10 watch: one output change per edge
  always @(negedge clk_i) begin
    if (rst_ni && $countones({pwr, dce, de, bl} ^ prev_o) > 1) n_multi++;
    prev_o = {pwr, dce, de, bl};
  end

  function automatic logic [3:0] outs();
    return {pwr, dce, de, bl};
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic set_dly(int p, int c, int b);
    P = p; C = c; B = b;
    d_pd = CW'(p); d_cd = CW'(c); d_db = CW'(b);
  endtask

  task automatic pix_probe(string req, bit on);
    repeat (4) @(posedge pix_clk_i);
    @(posedge pix_clk_i); #2;
    check({req, " clk high"}, 32'(pix_clk_o), 32'(on));
    check({req, " data"}, 32'(pix_data_o), on ? 32'(PAT_D) : 32'h0);
    check({req, " ctl"}, 32'(pix_ctl_o), on ? 32'(PAT_C) : 32'h0);
    @(negedge pix_clk_i); #2;
    check({req, " clk low"}, 32'(pix_clk_o), 32'h0);
  endtask

  task automatic go_up();
    @(negedge clk_i); en_i = 1'b1;
    step(1 + P + 1 + C + 1 + B + 1);
  endtask

  task automatic go_down();
    @(negedge clk_i); en_i = 1'b0;
    step(1 + B + 1 + C + 1 + P + 1);
  endtask

  task automatic t_reset();
    check("R1 outs in reset", 32'(outs()), 32'h0);
    pix_probe("R1 pix in reset", 1'b0);
    @(negedge clk_i); rst_ni = 1'b1;
    step(2);
    check("R1 outs after reset", 32'(outs()), 32'h0);
  endtask

  task automatic t_up();
    set_dly(3, 2, 4);
    @(negedge clk_i); en_i = 1'b1;
    step(1); check("R2 power first", 32'(outs()), 32'h8);
    step(P); check("R2 dce not early", 32'(outs()), 32'h8);
    step(1); check("R2 dce on", 32'(outs()), 32'hC);
    step(C); check("R2 de not early", 32'(outs()), 32'hC);
    step(1); check("R2 de on", 32'(outs()), 32'hE);
    step(B); check("R2 bl not early", 32'(outs()), 32'hE);
    step(1); check("R2 bl on", 32'(outs()), 32'hF);
    step(6); check("R3 bl held", 32'(outs()), 32'hF);
    pix_probe("R11 R12 pix on", 1'b1);
  endtask

  task automatic t_down();
    @(negedge clk_i); en_i = 1'b0;
    step(1); check("R3 bl drops at once", 32'(outs()), 32'hE);
    step(B); check("R4 de still on", 32'(outs()), 32'hE);
    step(1); check("R4 de off", 32'(outs()), 32'hC);
    step(C); check("R4 dce still on", 32'(outs()), 32'hC);
    step(1); check("R4 dce off", 32'(outs()), 32'h8);
    step(P); check("R4 pwr still on", 32'(outs()), 32'h8);
    step(1); check("R4 pwr off", 32'(outs()), 32'h0);
    step(5); check("R4 idle stays", 32'(outs()), 32'h0);
    pix_probe("R11 R12 pix off", 1'b0);
  endtask

  task automatic t_bl_return();
    go_up();
    @(negedge clk_i); en_i = 1'b0;
    step(1); check("R5 bl off", 32'(outs()), 32'hE);
    step(2);
    en_i = 1'b1;
    step(1); check("R5 bl back", 32'(outs()), 32'hF);
    step(B + 3); check("R5 no further drop", 32'(outs()), 32'hF);
    go_down();
    check("R5 down done", 32'(outs()), 32'h0);
  endtask

  task automatic t_mid_down_and_turn();
    go_up();
    @(negedge clk_i); en_i = 1'b0;
    step(1 + B + 1); check("R6 de off", 32'(outs()), 32'hC);
    en_i = 1'b1;
    step(C); check("R6 dce held", 32'(outs()), 32'hC);
    step(1); check("R6 dce still falls", 32'(outs()), 32'h8);
    step(P); check("R7 waiting", 32'(outs()), 32'h8);
    step(1); check("R7 power kept", 32'(outs()), 32'h8);
    step(P); check("R7 dce not early", 32'(outs()), 32'h8);
    step(1); check("R7 new power-up", 32'(outs()), 32'hC);
    step(C + 1 + B + 1); check("R7 full on", 32'(outs()), 32'hF);
    go_down();
  endtask

  task automatic t_up_abort();
    @(negedge clk_i); en_i = 1'b1;
    step(1 + P + 1); check("R8 dce on", 32'(outs()), 32'hC);
    en_i = 1'b0;
    step(C); check("R8 wait finishes", 32'(outs()), 32'hC);
    step(1); check("R8 dce reverses", 32'(outs()), 32'h8);
    step(P); check("R8 pwr held", 32'(outs()), 32'h8);
    step(1); check("R8 pwr off", 32'(outs()), 32'h0);
    @(negedge clk_i); en_i = 1'b1;
    step(1); check("R8 pwr on", 32'(outs()), 32'h8);
    en_i = 1'b0;
    step(P); check("R8 pwr wait", 32'(outs()), 32'h8);
    step(1); check("R8 pwr abort off", 32'(outs()), 32'h0);
  endtask

  task automatic t_zero();
    set_dly(0, 0, 0);
    @(negedge clk_i); en_i = 1'b1;
    step(1); check("R9 z pwr", 32'(outs()), 32'h8);
    step(1); check("R9 z dce", 32'(outs()), 32'hC);
    step(1); check("R9 z de", 32'(outs()), 32'hE);
    step(1); check("R9 z bl", 32'(outs()), 32'hF);
    en_i = 1'b0;
    step(1); check("R9 z bl off", 32'(outs()), 32'hE);
    step(1); check("R9 z de off", 32'(outs()), 32'hC);
    step(1); check("R9 z dce off", 32'(outs()), 32'h8);
    step(1); check("R9 z pwr off", 32'(outs()), 32'h0);
  endtask

  initial begin
    prev_o = 4'h0;
    set_dly(3, 2, 4);
    #30;
    t_reset();
    t_up();
    t_down();
    set_dly(2, 3, 5);
    t_bl_return();
    t_mid_down_and_turn();
    t_up_abort();
    t_zero();
    step(2);
    check("R10 single change per edge", 32'(n_multi), 32'h0);
    check("R12 gated clock edges clean", 32'(n_glitch), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule